// File: doc/BRIEF.md
# Path-matched trace cache

This block stores traces: runs of up to sixteen 32-bit instructions in the order a program runs them. Each trace carries the directions of the conditional branches it passes through. A fetch unit presents a start address and three branch predictions. One cycle later the block reports a hit, the trace's instructions and the address to fetch next. A way hits only when its stored tag matches the start address and the directions stored under its branch mask agree with the predictions. The next address is the trace's fall-through or its target, chosen from the prediction for the branch that ends the trace.

The storage is organised as 256 sets of 4 ways, which gives 64 KB of instruction words. Several ways of one set may hold traces that share a start address but follow different paths. A separate fill port writes a finished trace into the set its start address selects. The fill takes the lowest-numbered empty way, or else the least recently used way. Recency in each set is kept exactly across its four ways. A hit refreshes the recency of the way it used, and so does a fill.

Top module: `trace_cache`

## Requirements
- R1: After reset every way is empty, `hit_o` is 0, and `next_pc_o` and `instr_o` are all zeros.
- R2: A lookup address splits into the set index in bits [9:2] and the 22-bit tag in bits [31:10]. Bits [1:0] have no effect on the result.
- R3: A way hits only when it is filled, its tag equals the lookup tag, and `(mask & lookup_pred_i[2:1]) == (mask & flags)`. `lookup_pred_i[2]` is the first branch of the trace, `[1]` the second and `[0]` the third, and the same bit order holds for mask and flags.
- R4: The mask value 00 means the trace passes no branch, 10 means one and 11 means two. Prediction bits outside the mask have no effect on the hit.
- R5: On a hit, `next_pc_o` is the stored fall-through address when the trace does not end in a branch, or when its ending branch is predicted not-taken. The prediction for the ending branch is `lookup_pred_i[2-k]`, where k is the number of leading ones in the mask.
- R6: On a hit where the trace ends in a branch and that branch is predicted taken, `next_pc_o` is the stored target address.
- R7: A miss, and any cycle with `lookup_valid_i` low, gives `hit_o` = 0 with `next_pc_o` and `instr_o` at zero.
- R8: Ways of one set may hold traces with the same start address. If several ways hit, the lowest-numbered way supplies the output.
- R9: Outputs are registered and appear on the clock edge after the lookup. A lookup sees the contents from before any fill in the same cycle.
- R10: A fill writes the lowest-numbered empty way of its set, or else the least recently used way. The filled way and any hitting way become most recently used.
- R11: When a fill and a hit touch the same set in one cycle, only the fill changes that set's recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid_i | input | 1 | A lookup is presented this cycle |
| lookup_pc_i | input | 32 | Fetch start address |
| lookup_pred_i | input | 3 | Predicted directions, bit 2 for the first branch, 1 = taken |
| fill_en_i | input | 1 | Install a trace this cycle |
| fill_pc_i | input | 32 | Start address of the installed trace |
| fill_flags_i | input | 2 | Directions of the embedded branches |
| fill_mask_i | input | 2 | Count of embedded branches as leading ones |
| fill_ends_br_i | input | 1 | The trace ends in a conditional branch |
| fill_fall_i | input | 32 | Next address when the ending branch is not taken or absent |
| fill_target_i | input | 32 | Next address when the ending branch is taken |
| fill_instr_i | input | 512 | Sixteen instruction words, word 0 in the low bits |
| hit_o | output | 1 | Registered hit |
| next_pc_o | output | 32 | Registered next fetch address, zero on a miss |
| instr_o | output | 512 | Registered trace words, zero on a miss |

## Verification
The assertions assume that every address given to the fill port is word-aligned and that no fill uses the mask value 01. Under those conditions a hit can only return an aligned next address, and each set's recency order stays a permutation. The bench fills only aligned addresses and draws masks from the three legal codes. Its random phase confines the traffic to three sets and six tags. This keeps ways colliding, evictions frequent and same-set fill-and-hit cycles common.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int PATH_W = 2;          // branches that may sit inside a trace
    localparam int PRED_W = PATH_W + 1; // predictions per lookup

    typedef logic [PATH_W-1:0] path_t;
    typedef logic [PRED_W-1:0] pred_t;

    // number of ones counted from the MSB until the first zero
    function automatic int lead_ones(path_t m);
        int  n;
        bit  run;
        n   = 0;
        run = 1'b1;
        for (int i = PATH_W - 1; i >= 0; i--) begin
            if (run && m[i]) n++;
            else run = 1'b0;
        end
        return n;
    endfunction
endpackage

// File: rtl/tc_way_match.sv
module tc_way_match
    import tc_pkg::*;
#(
    parameter int TAG_W = 22
) (
    input  logic             valid_i,
    input  logic [TAG_W-1:0] stored_tag_i,
    input  logic [TAG_W-1:0] lookup_tag_i,
    input  path_t            mask_i,
    input  path_t            flags_i,
    input  pred_t            pred_i,
    output logic             hit_o
);
    path_t path_pred;
    logic  tag_eq;
    logic  path_eq;

    always_comb begin
        path_pred = pred_i[PRED_W-1 -: PATH_W];
        tag_eq    = (stored_tag_i == lookup_tag_i);
        path_eq   = ((mask_i & path_pred) == (mask_i & flags_i));
        hit_o     = valid_i && tag_eq && path_eq;
    end
endmodule

// File: rtl/tc_next_pc.sv
module tc_next_pc
    import tc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              ends_br_i,
    input  path_t             mask_i,
    input  pred_t             pred_i,
    input  logic [ADDR_W-1:0] fall_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    logic last_taken;
    int   inner;

    always_comb begin
        inner      = lead_ones(mask_i);
        last_taken = pred_i[PRED_W-1];
        for (int k = 1; k < PRED_W; k++) begin
            if (inner >= k) last_taken = pred_i[PRED_W-1-k];
        end
        next_pc_o = (ends_br_i && last_taken) ? target_i : fall_i;
    end
endmodule

// File: rtl/tc_lru.sv
module tc_lru #(
    parameter int SETS = 256,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit_en_i,
    input  logic [SET_W-1:0]            hit_set_i,
    input  logic [WAY_W-1:0]            hit_way_i,
    input  logic                        fill_en_i,
    input  logic [SET_W-1:0]            fill_set_i,
    input  logic [WAYS-1:0]             fill_valid_i,
    output logic [WAY_W-1:0]            victim_o,
    output logic [WAYS-1:0][WAY_W-1:0]  fill_ages_o
);
    typedef logic [WAYS-1:0][WAY_W-1:0] row_t;

    // age 0 = most recent, WAYS-1 = least recent
    row_t age_q [SETS];
    row_t hit_row_d;
    row_t fill_row_d;
    logic hit_write_d;

    function automatic row_t touch(row_t r, logic [WAY_W-1:0] w);
        row_t o;
        for (int i = 0; i < WAYS; i++) begin
            if (WAY_W'(i) == w)  o[i] = '0;
            else if (r[i] < r[w]) o[i] = r[i] + 1'b1;
            else                 o[i] = r[i];
        end
        return o;
    endfunction

    always_comb begin
        fill_ages_o = age_q[fill_set_i];
        victim_o    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (fill_ages_o[w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
        end
        if (!(&fill_valid_i)) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!fill_valid_i[w]) victim_o = WAY_W'(w);
            end
        end
        hit_row_d   = touch(age_q[hit_set_i], hit_way_i);
        fill_row_d  = touch(fill_ages_o, victim_o);
        hit_write_d = hit_en_i && !(fill_en_i && (fill_set_i == hit_set_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else begin
            if (hit_write_d) age_q[hit_set_i]  <= hit_row_d;
            if (fill_en_i)   age_q[fill_set_i] <= fill_row_d;
        end
    end
endmodule

// File: rtl/trace_cache.sv
module trace_cache
    import tc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SETS      = 256,
    parameter int WAYS      = 4,
    parameter int TRACE_LEN = 16,
    parameter int INSTR_W   = 32,
    localparam int OFF_W  = 2,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
    localparam int LINE_W = TRACE_LEN * INSTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid_i,
    input  logic [ADDR_W-1:0] lookup_pc_i,
    input  logic [PRED_W-1:0] lookup_pred_i,
    input  logic              fill_en_i,
    input  logic [ADDR_W-1:0] fill_pc_i,
    input  logic [PATH_W-1:0] fill_flags_i,
    input  logic [PATH_W-1:0] fill_mask_i,
    input  logic              fill_ends_br_i,
    input  logic [ADDR_W-1:0] fill_fall_i,
    input  logic [ADDR_W-1:0] fill_target_i,
    input  logic [LINE_W-1:0] fill_instr_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [LINE_W-1:0] instr_o
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        path_t             flags;
        path_t             mask;
        logic              ends_br;
        logic [ADDR_W-1:0] fall;
        logic [ADDR_W-1:0] target;
    } meta_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] npc;
        logic [LINE_W-1:0] line;
    } out_t;

    meta_t             meta_q [SETS][WAYS];
    logic [LINE_W-1:0] line_q [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];

    logic [SET_W-1:0]           lk_set;
    logic [TAG_W-1:0]           lk_tag;
    logic [SET_W-1:0]           fill_set;
    logic [WAYS-1:0]            way_hit;
    logic [WAY_W-1:0]           sel_way;
    logic                       any_hit;
    meta_t                      sel_meta;
    logic [ADDR_W-1:0]          sel_npc;
    meta_t                      fill_meta;
    logic [WAYS-1:0]            fill_valid_row;
    logic [WAY_W-1:0]           victim_way;
    logic [WAYS-1:0][WAY_W-1:0] fill_ages;
    logic                       unused_low_bits;
    out_t                       out_d;
    out_t                       out_q;

    assign lk_set          = lookup_pc_i[OFF_W +: SET_W];
    assign lk_tag          = lookup_pc_i[ADDR_W-1 -: TAG_W];
    assign fill_set        = fill_pc_i[OFF_W +: SET_W];
    assign fill_valid_row  = valid_q[fill_set];
    assign unused_low_bits = ^{lookup_pc_i[OFF_W-1:0], fill_pc_i[OFF_W-1:0]};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tc_way_match #(.TAG_W(TAG_W)) u_match (
            .valid_i      (valid_q[lk_set][w]),
            .stored_tag_i (meta_q[lk_set][w].tag),
            .lookup_tag_i (lk_tag),
            .mask_i       (meta_q[lk_set][w].mask),
            .flags_i      (meta_q[lk_set][w].flags),
            .pred_i       (lookup_pred_i),
            .hit_o        (way_hit[w])
        );
    end

    always_comb begin
        sel_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) sel_way = WAY_W'(w);
        end
        any_hit  = lookup_valid_i && (|way_hit);
        sel_meta = meta_q[lk_set][sel_way];
    end

    tc_next_pc #(.ADDR_W(ADDR_W)) u_npc (
        .ends_br_i (sel_meta.ends_br),
        .mask_i    (sel_meta.mask),
        .pred_i    (lookup_pred_i),
        .fall_i    (sel_meta.fall),
        .target_i  (sel_meta.target),
        .next_pc_o (sel_npc)
    );

    tc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_en_i     (any_hit),
        .hit_set_i    (lk_set),
        .hit_way_i    (sel_way),
        .fill_en_i    (fill_en_i),
        .fill_set_i   (fill_set),
        .fill_valid_i (fill_valid_row),
        .victim_o     (victim_way),
        .fill_ages_o  (fill_ages)
    );

    always_comb begin
        fill_meta.tag     = fill_pc_i[ADDR_W-1 -: TAG_W];
        fill_meta.flags   = fill_flags_i;
        fill_meta.mask    = fill_mask_i;
        fill_meta.ends_br = fill_ends_br_i;
        fill_meta.fall    = fill_fall_i;
        fill_meta.target  = fill_target_i;

        out_d = '0;
        if (any_hit) begin
            out_d.hit  = 1'b1;
            out_d.npc  = sel_npc;
            out_d.line = line_q[lk_set][sel_way];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else begin
            out_q <= out_d;
            if (fill_en_i) valid_q[fill_set][victim_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en_i) begin
            meta_q[fill_set][victim_way] <= fill_meta;
            line_q[fill_set][victim_way] <= fill_instr_i;
        end
    end

    assign hit_o     = out_q.hit;
    assign next_pc_o = out_q.npc;
    assign instr_o   = out_q.line;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4,
    parameter int LINE_W = 512,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       lookup_valid_i,
    input logic                       fill_en_i,
    input logic                       hit_o,
    input logic [ADDR_W-1:0]          next_pc_o,
    input logic [LINE_W-1:0]          instr_o,
    input logic [WAYS-1:0]            fill_valid_row,
    input logic [WAY_W-1:0]           victim_way,
    input logic [WAYS-1:0][WAY_W-1:0] fill_ages
);
    logic [WAYS-1:0] newest;

    always_comb begin
        for (int w = 0; w < WAYS; w++) newest[w] = (fill_ages[w] == '0);
    end

    assert_hit_after_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(lookup_valid_i));

    assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (next_pc_o == '0 && instr_o == '0));

    assert_pc_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (next_pc_o[1:0] == 2'b00));

    assert_single_newest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(newest) == 1);

    assert_victim_oldest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en_i && (&fill_valid_row)) |-> (fill_ages[victim_way] == WAY_W'(WAYS - 1)));
endmodule

bind trace_cache tc_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS), .LINE_W(LINE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lookup_valid_i (lookup_valid_i),
    .fill_en_i      (fill_en_i),
    .hit_o          (hit_o),
    .next_pc_o      (next_pc_o),
    .instr_o        (instr_o),
    .fill_valid_row (fill_valid_row),
    .victim_way     (victim_way),
    .fill_ages      (fill_ages)
);

// File: tb/trace_cache_test.sv
module trace_cache_test;
    localparam int SETS = 256;
    localparam int WAYS = 4;
    localparam int LW   = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_v = 1'b0;
    logic [31:0]   lk_pc = '0;
    logic [2:0]    lk_pred = '0;
    logic          f_v = 1'b0;
    logic [31:0]   f_pc = '0;
    logic [1:0]    f_flags = '0;
    logic [1:0]    f_mask = '0;
    logic          f_eib = 1'b0;
    logic [31:0]   f_ft = '0;
    logic [31:0]   f_tg = '0;
    int            f_seed = 0;
    logic [LW-1:0] f_line;
    logic          hit;
    logic [31:0]   npc;
    logic [LW-1:0] line;

    int vectors = 0;
    int errors  = 0;

    // reference state
    bit          m_val   [SETS][WAYS];
    logic [21:0] m_tag   [SETS][WAYS];
    logic [1:0]  m_flags [SETS][WAYS];
    logic [1:0]  m_mask  [SETS][WAYS];
    bit          m_eib   [SETS][WAYS];
    logic [31:0] m_ft    [SETS][WAYS];
    logic [31:0] m_tg    [SETS][WAYS];
    int          m_seed  [SETS][WAYS];
    int          recency [SETS][$];   // front = most recent

    always #4 clk = ~clk;

    function automatic logic [LW-1:0] line_of(int seed);
        logic [LW-1:0] l;
        for (int j = 0; j < 16; j++)
            l[j*32 +: 32] = (32'(seed) * 32'h9E37) + (32'(j) * 32'h101) ^ 32'h5A00_0000;
        return l;
    endfunction

    function automatic logic [31:0] mkpc(int tag, int idx);
        return {22'(tag), 8'(idx), 2'b00};
    endfunction

    assign f_line = line_of(f_seed);

    trace_cache uut (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid_i(lk_v), .lookup_pc_i(lk_pc), .lookup_pred_i(lk_pred),
        .fill_en_i(f_v), .fill_pc_i(f_pc), .fill_flags_i(f_flags), .fill_mask_i(f_mask),
        .fill_ends_br_i(f_eib), .fill_fall_i(f_ft), .fill_target_i(f_tg), .fill_instr_i(f_line),
        .hit_o(hit), .next_pc_o(npc), .instr_o(line)
    );

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            recency[s] = {};
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0;
                recency[s].push_back(w);
            end
        end
    endtask

    task automatic touch(int s, int w);
        for (int i = 0; i < recency[s].size(); i++) begin
            if (recency[s][i] == w) begin
                recency[s].delete(i);
                break;
            end
        end
        recency[s].push_front(w);
    endtask

    // one clock: predict from the model, advance it, then compare at the next falling edge
    task automatic step(string req);
        bit            e_hit;
        logic [31:0]   e_npc;
        logic [LW-1:0] e_line;
        int            hw, s, fs, vic, n;
        logic          last;
        e_hit = 0; e_npc = '0; e_line = '0; hw = -1;
        s  = int'(lk_pc[9:2]);
        fs = int'(f_pc[9:2]);
        if (lk_v) begin
            for (int w = 0; w < WAYS; w++) begin
                if (hw < 0 && m_val[s][w] && m_tag[s][w] == lk_pc[31:10] &&
                    ((m_mask[s][w] & lk_pred[2:1]) == (m_mask[s][w] & m_flags[s][w])))
                    hw = w;
            end
            if (hw >= 0) begin
                e_hit  = 1;
                e_line = line_of(m_seed[s][hw]);
                n = 0;
                if (m_mask[s][hw][1]) n = m_mask[s][hw][0] ? 2 : 1;
                last  = lk_pred[2-n];
                e_npc = (m_eib[s][hw] && last) ? m_tg[s][hw] : m_ft[s][hw];
            end
        end
        if (hw >= 0 && !(f_v && fs == s)) touch(s, hw);
        if (f_v) begin
            vic = -1;
            for (int w = 0; w < WAYS; w++) if (vic < 0 && !m_val[fs][w]) vic = w;
            if (vic < 0) vic = recency[fs][WAYS-1];
            m_val[fs][vic]   = 1;
            m_tag[fs][vic]   = f_pc[31:10];
            m_flags[fs][vic] = f_flags;
            m_mask[fs][vic]  = f_mask;
            m_eib[fs][vic]   = f_eib;
            m_ft[fs][vic]    = f_ft;
            m_tg[fs][vic]    = f_tg;
            m_seed[fs][vic]  = f_seed;
            touch(fs, vic);
        end
        @(posedge clk);
        @(negedge clk);
        vectors++;
        if (hit !== e_hit || npc !== e_npc || line !== e_line) begin
            errors++;
            $display("FAIL %s: hit=%0b next_pc=%h word0=%h, expected hit=%0b next_pc=%h word0=%h",
                     req, hit, npc, line[31:0], e_hit, e_npc, e_line[31:0]);
        end
        lk_v = 1'b0;
        f_v  = 1'b0;
    endtask

    task automatic set_look(logic [31:0] pc, logic [2:0] pred);
        lk_v = 1'b1; lk_pc = pc; lk_pred = pred;
    endtask

    task automatic set_fill(logic [31:0] pc, logic [1:0] flags, logic [1:0] mask, logic eib,
                            logic [31:0] ft, logic [31:0] tg, int seed);
        f_v = 1'b1; f_pc = pc; f_flags = flags; f_mask = mask; f_eib = eib;
        f_ft = ft; f_tg = tg; f_seed = seed;
    endtask

    task automatic look(logic [31:0] pc, logic [2:0] pred, string req);
        set_look(pc, pred);
        step(req);
    endtask

    task automatic fill(logic [31:0] pc, logic [1:0] flags, logic [1:0] mask, logic eib,
                        logic [31:0] ft, logic [31:0] tg, int seed, string req);
        set_fill(pc, flags, mask, eib, ft, tg, seed);
        step(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run still going, expected it to end");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle cycle and lookups into empty storage
        step("R1");
        look(mkpc(1, 5), 3'b000, "R1");
        look(mkpc(9, 200), 3'b111, "R1");

        // R7: install a plain trace; a lookup with valid low must miss
        fill(mkpc(1, 5), 2'b00, 2'b00, 1'b0, 32'h0000_1000, 32'h0000_2000, 11, "R10");
        lk_pc = mkpc(1, 5); step("R7");
        look(mkpc(1, 5), 3'b101, "R3 R5");
        // R2: low address bits ignored, other tag misses, other set misses
        look(mkpc(1, 5) | 32'h3, 3'b000, "R2");
        look(mkpc(2, 5), 3'b000, "R2");
        look(mkpc(1, 6), 3'b000, "R2");

        // R6: trace ending in a branch with no inner branches uses pred[2]
        fill(mkpc(3, 7), 2'b00, 2'b00, 1'b1, 32'h0000_3000, 32'h0000_4000, 12, "R10");
        look(mkpc(3, 7), 3'b100, "R6");
        look(mkpc(3, 7), 3'b011, "R5");

        // R4: one inner branch, flag bit 0 outside the mask
        fill(mkpc(4, 9), 2'b10, 2'b10, 1'b1, 32'h0000_5000, 32'h0000_6000, 13, "R10");
        look(mkpc(4, 9), 3'b110, "R4 R6");
        look(mkpc(4, 9), 3'b100, "R4 R5");
        look(mkpc(4, 9), 3'b101, "R4 R5");
        look(mkpc(4, 9), 3'b010, "R4 R3");
        look(mkpc(4, 9), 3'b111, "R4");

        // R4: two inner branches, ending branch uses pred[0]
        fill(mkpc(5, 11), 2'b01, 2'b11, 1'b1, 32'h0000_7000, 32'h0000_8000, 14, "R10");
        look(mkpc(5, 11), 3'b010, "R4 R5");
        look(mkpc(5, 11), 3'b011, "R4 R6");
        look(mkpc(5, 11), 3'b000, "R4 R3");
        look(mkpc(5, 11), 3'b110, "R4 R3");

        // R8: same start address, different paths, plus a duplicate path
        fill(mkpc(6, 20), 2'b00, 2'b11, 1'b0, 32'h0000_A000, 32'h0000_A100, 20, "R8");
        fill(mkpc(6, 20), 2'b01, 2'b11, 1'b0, 32'h0000_B000, 32'h0000_B100, 21, "R8");
        fill(mkpc(6, 20), 2'b10, 2'b11, 1'b0, 32'h0000_C000, 32'h0000_C100, 22, "R8");
        fill(mkpc(6, 20), 2'b00, 2'b00, 1'b0, 32'h0000_D000, 32'h0000_D100, 23, "R8");
        look(mkpc(6, 20), 3'b000, "R8");
        look(mkpc(6, 20), 3'b010, "R8");
        look(mkpc(6, 20), 3'b100, "R8");
        look(mkpc(6, 20), 3'b110, "R8");

        // R10: full set, refresh some ways then evict the oldest
        look(mkpc(6, 20), 3'b000, "R10");
        fill(mkpc(7, 20), 2'b00, 2'b00, 1'b1, 32'h0000_E000, 32'h0000_E100, 24, "R10");
        look(mkpc(6, 20), 3'b010, "R10");
        look(mkpc(6, 20), 3'b100, "R10");
        look(mkpc(7, 20), 3'b100, "R10");

        // R9 and R11: hit and fill in the same set and cycle
        set_look(mkpc(6, 20), 3'b000);
        set_fill(mkpc(8, 20), 2'b00, 2'b00, 1'b0, 32'h0000_F000, 32'h0000_F100, 25);
        step("R11");
        fill(mkpc(9, 20), 2'b00, 2'b00, 1'b0, 32'h0001_0000, 32'h0001_0100, 26, "R11");
        look(mkpc(6, 20), 3'b000, "R11");
        set_look(mkpc(3, 30), 3'b000);
        set_fill(mkpc(3, 30), 2'b00, 2'b00, 1'b0, 32'h0001_1000, 32'h0001_1100, 27);
        step("R9");
        look(mkpc(3, 30), 3'b000, "R9");

        // random traffic over three sets and six tags
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] mk;
            int r;
            r  = $urandom_range(0, 2);
            mk = (r == 0) ? 2'b00 : ((r == 1) ? 2'b10 : 2'b11);
            if ($urandom_range(0, 99) < 60)
                set_look(mkpc($urandom_range(0, 5), 40 + $urandom_range(0, 2)) |
                         32'($urandom_range(0, 3)), 3'($urandom));
            if ($urandom_range(0, 99) < 35)
                set_fill(mkpc($urandom_range(0, 5), 40 + $urandom_range(0, 2)), 2'($urandom), mk,
                         1'($urandom), $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, 100 + i);
            step("R3 R5 R6 R8 R10 R11");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule